// File: doc/BRIEF.md
# Serial Management Slave with Preamble Suppression

This block is the device-side end of a two-wire serial management bus. It samples the bidirectional data line on each rising edge of the management clock and decodes frames. Each frame has a start pattern, a two-bit opcode, a 5-bit device address, a 5-bit register address, a two-bit turnaround and a 16-bit data word. When the device address matches the strap input, the block reads or writes a small register file. Read data goes back on the same wire through an output enable, and the external pull-up supplies the released level.

After a hardware reset, or a software reset through the control register, the block stays silent until the line has carried 32 consecutive ones. From then on it never needs that long preamble again. Any frame that follows a single idle one is accepted. The status register advertises this capability, so a management controller can drop preambles for the rest of the session.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset, `mdio_oe` is 0 and no frame is answered until 32 consecutive ones have been sampled. A 0 sampled earlier restarts that count.
- R2: Once the preamble has been seen, a read frame (start 0,1; opcode 1,0) to the strap address returns the addressed register.
- R3: After the preamble, a frame that starts right after a single idle 1 bit is decoded. This holds for both reads and writes that follow one another.
- R4: Start must be 0 then 1, and only opcodes 1,0 (read) and 0,1 (write) are valid. A wrong start bit or opcode 0,0 or 1,1 drops the frame. The next valid frame after one idle bit is then answered, with no new preamble.
- R5: On a read, `mdio_oe` rises after the edge that samples the first turnaround bit and `mdio_o` is 0 for that bit period. The 16 data bits follow MSB first, one per period, each updated after a rising edge. `mdio_oe` falls after the edge that samples the last data bit.
- R6: A write frame (turnaround 1,0) stores its 16 data bits, MSB first, into the addressed register, and a later read returns them.
- R7: A frame whose device address differs from `phy_strap` never asserts `mdio_oe` and changes no register.
- R8: Address 1 is read-only and returns `STATUS_CAPS` with bit 6 forced to 1 (16'h7849 by default). Addresses 2 and 3 return `ID_HI` (16'h1C2D) and `ID_LO` (16'h4E51). Unmapped addresses read 0 and ignore writes.
- R9: Address 0 is the control register. Bits 14:0 are read/write and bit 15 reads 0. Writing bit 15 as 1 clears the control and scratch registers and requires a fresh 32-one preamble.
- R10: Addresses `SCR_BASE` to `SCR_BASE+N_SCR-1` (16 to 19 by default) are independent 16-bit read/write scratch registers that reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phy_strap | input | 5 | Device address this slave answers to |
| mdio_i | input | 1 | Sampled level of the data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line driver |

## Verification
The hardest state to reach from the ports is the gap between arming and losing the armed state. A one-time preamble must be proven neither too early nor needed twice. The stimulus sends exactly 31 ones and then a valid read, which must stay unanswered. It then sends 32 ones, and later injects bad start and opcode patterns followed by a single idle bit and a valid read. Finally a software reset is written and the bench shows that the next read goes unanswered until a new full preamble. A sweep over all 31 foreign device addresses, with reads and writes, confirms the line is never driven and no register changes.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int unsigned MGMT_DATA_W   = 16;
  localparam int unsigned MGMT_ADDR_W   = 5;
  localparam int unsigned SUPPRESS_BIT  = 6;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_OP,
    FS_PHY,
    FS_REG,
    FS_TA,
    FS_DATA
  } frm_state_t;

endpackage

// File: rtl/mgmt_preamble.sv
module mgmt_preamble #(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_in,
  output logic armed
);

  localparam int unsigned CNT_W = $clog2(PRE_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRE_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (clr) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (!armed_q) begin
      if (bit_in) begin
        if (cnt_q == CNT_LAST) begin
          armed_d = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/mgmt_frame_rx.sv
module mgmt_frame_rx
  import mgmt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              bit_in,
  input  logic [ADDR_W-1:0] strap,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wdata,
  output logic              drv_oe,
  output logic              drv_bit,
  output logic              in_idle
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  frm_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              op_hi_q, op_hi_d;
  logic              is_rd_q, is_rd_d;
  logic              hit_q, hit_d;
  logic              idle1_q, idle1_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] reg_q, reg_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              out_q, out_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_hi_d = op_hi_q;
    is_rd_d = is_rd_q;
    hit_d   = hit_q;
    idle1_d = idle1_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    out_d   = out_q;
    unique case (state_q)
      FS_IDLE: begin
        idle1_d = bit_in;
        if (armed && idle1_q && !bit_in) begin
          state_d = FS_START;
          idle1_d = 1'b0;
        end
      end
      FS_START: begin
        cnt_d   = '0;
        state_d = bit_in ? FS_OP : FS_IDLE;
      end
      FS_OP: begin
        if (cnt_q == '0) begin
          op_hi_d = bit_in;
          cnt_d   = CNT_W'(1);
        end else begin
          cnt_d = '0;
          if ({op_hi_q, bit_in} == OPC_READ) begin
            is_rd_d = 1'b1;
            state_d = FS_PHY;
          end else if ({op_hi_q, bit_in} == OPC_WRITE) begin
            is_rd_d = 1'b0;
            state_d = FS_PHY;
          end else begin
            state_d = FS_IDLE;
          end
        end
      end
      FS_PHY: begin
        phy_d = {phy_q[ADDR_W-2:0], bit_in};
        if (cnt_q == ADDR_LAST) begin
          cnt_d   = '0;
          state_d = FS_REG;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      FS_REG: begin
        reg_d = {reg_q[ADDR_W-2:0], bit_in};
        if (cnt_q == ADDR_LAST) begin
          cnt_d   = '0;
          hit_d   = (phy_q == strap);
          state_d = FS_TA;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      FS_TA: begin
        if (cnt_q == '0) begin
          cnt_d = CNT_W'(1);
          if (is_rd_q && hit_q) begin
            oe_d  = 1'b1;
            out_d = 1'b0;
            sh_d  = rdata;
          end
        end else begin
          cnt_d   = '0;
          sh_d    = {sh_q[DATA_W-2:0], bit_in};
          out_d   = oe_q ? sh_q[DATA_W-1] : 1'b0;
          state_d = FS_DATA;
        end
      end
      FS_DATA: begin
        sh_d  = {sh_q[DATA_W-2:0], bit_in};
        out_d = oe_q ? sh_q[DATA_W-1] : 1'b0;
        if (cnt_q == DATA_LAST) begin
          cnt_d   = '0;
          oe_d    = 1'b0;
          out_d   = 1'b0;
          idle1_d = 1'b0;
          state_d = FS_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      op_hi_q <= 1'b0;
      is_rd_q <= 1'b0;
      hit_q   <= 1'b0;
      idle1_q <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_hi_q <= op_hi_d;
      is_rd_q <= is_rd_d;
      hit_q   <= hit_d;
      idle1_q <= idle1_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      out_q   <= out_d;
    end
  end

  assign reg_addr = reg_q;
  assign wr_en    = (state_q == FS_DATA) && (cnt_q == DATA_LAST) && !is_rd_q && hit_q;
  assign wdata    = {sh_q[DATA_W-2:0], bit_in};
  assign drv_oe   = oe_q;
  assign drv_bit  = out_q;
  assign in_idle  = (state_q == FS_IDLE);

endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mgmt_pkg::*;
#(
  parameter int unsigned       DATA_W      = 16,
  parameter int unsigned       ADDR_W      = 5,
  parameter int unsigned       N_SCR       = 4,
  parameter int unsigned       SCR_BASE    = 16,
  parameter logic [DATA_W-1:0] STATUS_CAPS = 16'h7809,
  parameter logic [DATA_W-1:0] ID_HI       = 16'h1C2D,
  parameter logic [DATA_W-1:0] ID_LO       = 16'h4E51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              soft_rst
);

  localparam logic [DATA_W-1:0] STATUS_VAL = STATUS_CAPS | (DATA_W'(1) << SUPPRESS_BIT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IDHI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IDLO = ADDR_W'(3);

  logic [DATA_W-2:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic [DATA_W-1:0] scr_q [N_SCR];

  assign soft_rst = wr_en && (addr == A_CTRL) && wdata[DATA_W-1];
  assign ctrl_en  = wr_en && (addr == A_CTRL);
  assign ctrl_d   = soft_rst ? '0 : wdata[DATA_W-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar g = 0; g < N_SCR; g++) begin : g_scr
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SCR_BASE + g);
    logic en;
    assign en = soft_rst || (wr_en && (addr == SLOT));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scr_q[g] <= '0;
      end else if (en) begin
        scr_q[g] <= soft_rst ? '0 : wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  rdata = {1'b0, ctrl_q};
      A_STAT:  rdata = STATUS_VAL;
      A_IDHI:  rdata = ID_HI;
      A_IDLO:  rdata = ID_LO;
      default: rdata = '0;
    endcase
    for (int i = 0; i < N_SCR; i++) begin
      if (addr == ADDR_W'(SCR_BASE + i)) rdata = scr_q[i];
    end
  end

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
  import mgmt_pkg::*;
#(
  parameter int unsigned            PRE_LEN     = 32,
  parameter int unsigned            N_SCR       = 4,
  parameter int unsigned            SCR_BASE    = 16,
  parameter logic [MGMT_DATA_W-1:0] STATUS_CAPS = 16'h7809,
  parameter logic [MGMT_DATA_W-1:0] ID_HI       = 16'h1C2D,
  parameter logic [MGMT_DATA_W-1:0] ID_LO       = 16'h4E51
) (
  input  logic                   mdc,
  input  logic                   rst_n,
  input  logic [MGMT_ADDR_W-1:0] phy_strap,
  input  logic                   mdio_i,
  output logic                   mdio_o,
  output logic                   mdio_oe
);

  logic [1:0]             rst_pipe;
  logic                   rst_q_n;
  logic                   armed;
  logic                   soft_rst;
  logic                   wr_en;
  logic                   fr_idle;
  logic [MGMT_ADDR_W-1:0] reg_addr;
  logic [MGMT_DATA_W-1:0] wdata;
  logic [MGMT_DATA_W-1:0] rdata;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  mgmt_preamble #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk    (mdc),
    .rst_n  (rst_q_n),
    .clr    (soft_rst),
    .bit_in (mdio_i),
    .armed  (armed)
  );

  mgmt_frame_rx #(.DATA_W(MGMT_DATA_W), .ADDR_W(MGMT_ADDR_W)) u_frm (
    .clk      (mdc),
    .rst_n    (rst_q_n),
    .armed    (armed),
    .bit_in   (mdio_i),
    .strap    (phy_strap),
    .rdata    (rdata),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .drv_oe   (mdio_oe),
    .drv_bit  (mdio_o),
    .in_idle  (fr_idle)
  );

  mgmt_regs #(
    .DATA_W      (MGMT_DATA_W),
    .ADDR_W      (MGMT_ADDR_W),
    .N_SCR       (N_SCR),
    .SCR_BASE    (SCR_BASE),
    .STATUS_CAPS (STATUS_CAPS),
    .ID_HI       (ID_HI),
    .ID_LO       (ID_LO)
  ) u_regs (
    .clk      (mdc),
    .rst_n    (rst_q_n),
    .wr_en    (wr_en),
    .addr     (reg_addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .soft_rst (soft_rst)
  );

endmodule

// File: rtl/mgmt_serial_chk.sv
module mgmt_serial_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic armed,
  input logic mdio_oe,
  input logic mdio_o,
  input logic in_idle,
  input logic wr_en,
  input logic soft_rst
);

  logic [5:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run <= '0;
    end else if (!mdio_oe) begin
      oe_run <= '0;
    end else begin
      oe_run <= oe_run + 6'd1;
    end
  end

  AST_NO_DRIVE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !mdio_oe); // R1

  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R5

  AST_DRIVE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    oe_run <= 6'(DATA_W + 1)); // R5

  AST_IDLE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> in_idle); // R5

  AST_NO_WRITE_WHILE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mdio_oe); // R6

  AST_SOFT_RESET_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !armed); // R9

endmodule

bind mgmt_serial_slave mgmt_serial_chk #(.DATA_W(16)) u_chk (
  .clk      (mdc),
  .rst_n    (rst_q_n),
  .armed    (armed),
  .mdio_oe  (mdio_oe),
  .mdio_o   (mdio_o),
  .in_idle  (fr_idle),
  .wr_en    (wr_en),
  .soft_rst (soft_rst)
);

// File: tb/mgmt_serial_slave_tb.sv
module mgmt_serial_slave_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [4:0]  STRAP      = 5'd9;
  localparam logic [15:0] EXP_STATUS = 16'h7849;
  localparam logic [15:0] EXP_IDHI   = 16'h1C2D;
  localparam logic [15:0] EXP_IDLO   = 16'h4E51;
  localparam int unsigned SCR_BASE   = 16;
  localparam int unsigned N_SCR      = 4;

  logic clk;
  logic rst_n;
  logic st_oe;
  logic st_val;
  logic dut_o;
  logic dut_oe;
  logic line;
  int   total;
  int   bad;

  assign line = dut_oe ? dut_o : (st_oe ? st_val : 1'b1);

  mgmt_serial_slave dut_i (
    .mdc       (clk),
    .rst_n     (rst_n),
    .phy_strap (STRAP),
    .mdio_i    (line),
    .mdio_o    (dut_o),
    .mdio_oe   (dut_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    @(negedge clk);
    st_oe  = 1'b1;
    st_val = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'hA5C3 ^ 16'(16'h1111 * i);
  endfunction

  task automatic rd(input logic [4:0] pa, input logic [4:0] ra,
                    output logic [15:0] d, output logic ok, output logic any);
    drive(1'b0); drive(1'b1); drive(1'b1); drive(1'b0);
    for (int i = 4; i >= 0; i--) drive(pa[i]);
    for (int i = 4; i >= 0; i--) drive(ra[i]);
    @(negedge clk);
    st_oe = 1'b0;
    ok  = 1'b1;
    any = 1'b0;
    d   = '0;
    @(negedge clk);
    any = any | dut_oe;
    if (!(dut_oe && !dut_o)) ok = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      any = any | dut_oe;
      if (!dut_oe) ok = 1'b0;
      d = {d[14:0], line};
    end
    @(negedge clk);
    any = any | dut_oe;
    if (dut_oe) ok = 1'b0;
  endtask

  task automatic wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] v);
    drive(1'b0); drive(1'b1); drive(1'b0); drive(1'b1);
    for (int i = 4; i >= 0; i--) drive(pa[i]);
    for (int i = 4; i >= 0; i--) drive(ra[i]);
    drive(1'b1); drive(1'b0);
    for (int i = 15; i >= 0; i--) drive(v[i]);
    idle(1);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic ok;
    logic any;
    total  = 0;
    bad    = 0;
    rst_n  = 1'b0;
    st_oe  = 1'b1;
    st_val = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset oe", 32'(dut_oe), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", 32'(dut_oe), 32'd0);

    // R1: 31 ones are one short of arming
    idle(31);
    rd(STRAP, 5'd1, d, ok, any);
    chk("R1 no answer after 31 ones", 32'(any), 32'd0);

    // R2/R8: full preamble, then status and ids
    idle(32);
    rd(STRAP, 5'd1, d, ok, any);
    chk("R2 read answered", 32'(ok), 32'd1);
    chk("R8 status value", 32'(d), 32'(EXP_STATUS));
    rd(STRAP, 5'd2, d, ok, any);
    chk("R8 id high", 32'(d), 32'(EXP_IDHI));
    rd(STRAP, 5'd3, d, ok, any);
    chk("R8 id low", 32'(d), 32'(EXP_IDLO));
    rd(STRAP, 5'd7, d, ok, any);
    chk("R5 drive shape unmapped", 32'(ok), 32'd1);
    chk("R8 unmapped reads zero", 32'(d), 32'd0);

    // R10 reset values
    for (int i = 0; i < N_SCR; i++) begin
      rd(STRAP, 5'(SCR_BASE + i), d, ok, any);
      chk("R10 scratch reset zero", 32'(d), 32'd0);
    end

    // R6/R3/R10: write all scratch registers with one idle bit between frames
    for (int i = 0; i < N_SCR; i++) wr(STRAP, 5'(SCR_BASE + i), pat(i));
    for (int i = 0; i < N_SCR; i++) begin
      rd(STRAP, 5'(SCR_BASE + i), d, ok, any);
      chk("R3 R5 read after one idle", 32'(ok), 32'd1);
      chk("R6 R10 scratch readback", 32'(d), 32'(pat(i)));
    end

    // R9: control bits 14:0
    wr(STRAP, 5'd0, 16'h7FFF);
    rd(STRAP, 5'd0, d, ok, any);
    chk("R9 control all ones", 32'(d), 32'h7FFF);
    wr(STRAP, 5'd0, 16'h1234);
    rd(STRAP, 5'd0, d, ok, any);
    chk("R9 control pattern", 32'(d), 32'h1234);

    // R8: read-only and unmapped writes
    wr(STRAP, 5'd1, 16'h0000);
    rd(STRAP, 5'd1, d, ok, any);
    chk("R8 status read-only", 32'(d), 32'(EXP_STATUS));
    wr(STRAP, 5'd7, 16'hBEEF);
    rd(STRAP, 5'd7, d, ok, any);
    chk("R8 unmapped write ignored", 32'(d), 32'd0);

    // R7: sweep every foreign device address
    for (int a = 0; a < 32; a++) begin
      if (5'(a) != STRAP) begin
        rd(5'(a), 5'(SCR_BASE), d, ok, any);
        chk("R7 foreign read not driven", 32'(any), 32'd0);
        wr(5'(a), 5'(SCR_BASE), 16'hDEAD ^ 16'(a));
      end
    end
    rd(STRAP, 5'(SCR_BASE), d, ok, any);
    chk("R7 foreign writes ignored", 32'(d), 32'(pat(0)));

    // R4: bad opcode 00, bad opcode 11, bad start
    drive(1'b0); drive(1'b1); drive(1'b0); drive(1'b0);
    idle(2);
    rd(STRAP, 5'(SCR_BASE + 1), d, ok, any);
    chk("R4 recover after opcode 00", 32'(d), 32'(pat(1)));
    drive(1'b0); drive(1'b1); drive(1'b1); drive(1'b1);
    idle(2);
    rd(STRAP, 5'(SCR_BASE + 2), d, ok, any);
    chk("R4 recover after opcode 11", 32'(d), 32'(pat(2)));
    drive(1'b0); drive(1'b0);
    idle(1);
    rd(STRAP, 5'(SCR_BASE + 3), d, ok, any);
    chk("R4 recover after bad start", 32'(ok), 32'd1);
    chk("R4 data after bad start", 32'(d), 32'(pat(3)));

    // R9: software reset needs a new preamble and clears registers
    wr(STRAP, 5'd0, 16'h8000);
    rd(STRAP, 5'd0, d, ok, any);
    chk("R9 silent after soft reset", 32'(any), 32'd0);
    idle(32);
    rd(STRAP, 5'd0, d, ok, any);
    chk("R9 answered after new preamble", 32'(ok), 32'd1);
    chk("R9 control cleared", 32'(d), 32'd0);
    rd(STRAP, 5'(SCR_BASE), d, ok, any);
    chk("R9 scratch cleared", 32'(d), 32'd0);

    finish_run();
  end

endmodule